// File: doc/BRIEF.md
# Instruction Issue and Flush Sequencer

This block paces instruction issue for a small 8-bit controller core whose program memory holds 16-bit words. It divides the oscillator into instruction cycles of four phases and raises one phase strobe per oscillator period. It also keeps the fetch address and holds one issue slot that the execute stage reads. The word fetched in one cycle is issued in the next. An opcode decoder outside the block marks the first word of each two-word instruction. The execute stage reports back whether the issued instruction was a taken conditional, a skip or a program-counter write.

When the execute stage reports a redirect, the slot that follows becomes a bubble. A bubble is a no-operation cycle with the squash flag raised for the whole cycle, so downstream registers, flags and memory are left untouched. A two-word instruction spends its first cycle gathering the second word and executes in its second cycle, with both words presented together. The second word of every two-word instruction has its four upper bits set to one. Any such word that enters the slot on its own is issued as a bubble, so a skip or jump that lands on it costs one harmless cycle.

Top module: `iss_issue_seq`

## Requirements
- R1: While reset is low, and in the cycle after it rises, the first phase strobe is the only strobe high, the fetch address is zero and exec_en is low. Instruction cycle 0 after reset is a bubble (squash high), and the word at address 0 executes in cycle 1.
- R2: phase_strobe is one-hot and rotates from bit 0 to bit 3 on successive oscillator edges, so one instruction cycle lasts four oscillator periods.
- R3: The fetch address changes only at the clock edge that ends phase 3. At that edge it advances by one word unless a program-counter write is taken, so straight-line code executes one instruction per cycle.
- R4: When ex_pc_write is high during an exec_en strobe, the fetch address loads ex_target at the end of that cycle. The following cycle is a bubble, so a redirecting single-word instruction takes two cycles.
- R5: When ex_taken or ex_skip is high during an exec_en strobe, the following cycle is a bubble and the fetch address keeps stepping by one. A skip over a single-word instruction therefore costs two cycles in total.
- R6: A word that dbl_first marks as a first word gives a gather cycle with both exec_en and squash low. The next cycle raises exec_en with exec_word equal to the first word and exec_ext equal to the second, so the instruction takes two cycles.
- R7: A word whose bits 15:12 are all ones that enters the slot other than as the second half of a two-word instruction is issued as a bubble. This makes a skip over a two-word instruction cost three cycles and makes a jump landing on a second word a one-cycle no-operation.
- R8: A two-word instruction that writes the program counter takes three cycles: a gather cycle, an execute cycle and one bubble.
- R9: exec_dest equals bit 9 of exec_word (0 selects the working register, 1 the addressed file register) whenever exec_en is high.
- R10: ex_taken, ex_skip, ex_pc_write and ex_target have no effect outside an exec_en strobe.
- R11: exec_en is high only in phase 3 of a non-bubble issue cycle, and squash holds one value across all four phases of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_word | input | 16 | Program word read at fetch_addr, valid by phase 3 |
| dbl_first | input | 1 | Decoder mark: prog_word is the first word of a two-word instruction |
| ex_taken | input | 1 | Execute stage: conditional test true |
| ex_skip | input | 1 | Execute stage: skip the next instruction |
| ex_pc_write | input | 1 | Execute stage: load ex_target into the fetch address |
| ex_target | input | 12 | Redirect word address |
| phase_strobe | output | 4 | One-hot phase strobes |
| fetch_addr | output | 12 | Word address being fetched |
| exec_en | output | 1 | Execute strobe in phase 3 of an issued cycle |
| exec_word | output | 16 | Issued word (first word of a two-word instruction) |
| exec_ext | output | 16 | Second word during a two-word execute cycle, else zero |
| exec_dest | output | 1 | Result destination bit forwarded from the issued word |
| squash | output | 1 | High for the whole of a bubble cycle |

## Verification
The properties assume that the execute stage drives its flags as a pure function of the issued word and only means them during exec_en, that prog_word is settled by phase 3, and that the decoder never marks a word with all-ones upper bits as a first word. The bench's execute stage decodes exec_word and exec_ext combinationally while exec_en is high and drives random noise on every flag and on the target otherwise. That noise tests the input-ignoring rule without ever violating the assumptions. The program generator always places an all-ones-nibble word after each first word and marks only opcode 0xC as two-word. Directed programs cover straight-line code, skips over both instruction sizes, redirects of both sizes and a jump onto a second word.

// File: rtl/iss_pkg.sv
// Shared types for the issue sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package iss_pkg;

    // Contents of the issue slot for the current instruction cycle.
    typedef enum logic [1:0] {
        SLOT_BUBBLE = 2'd0,  // inserted no-op, squash raised
        SLOT_HEAD   = 2'd1,  // first word of a two-word op, gathering
        SLOT_TAIL   = 2'd2,  // second word present, two-word op executes
        SLOT_SOLO   = 2'd3   // single-word op executes
    } slot_kind_e;

endpackage

// File: rtl/iss_phase_gen.sv
// Phase generator: divides the oscillator into instruction cycles of
// PHASES periods and drives one-hot phase strobes.
// Assumes: PHASES >= 2; reset is synchronous and active low.
module iss_phase_gen #(
    parameter int PHASES = 4
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    output logic [PHASES-1:0] strobe,
    output logic              last
);
    localparam int CW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [CW-1:0] LAST_PH = CW'(PHASES - 1);

    logic [CW-1:0] cnt_q;

    // Phase counter, wraps after the last phase.
    always_ff @(posedge clk_osc) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST_PH)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // One strobe per phase decoded from the counter.
    for (genvar g = 0; g < PHASES; g++) begin : g_strobe
        assign strobe[g] = (cnt_q == CW'(g));
    end

    assign last = strobe[PHASES-1];
endmodule

// File: rtl/iss_fetch_ptr.sv
// Fetch pointer: holds the word address being fetched; steps by one at
// each cycle boundary or loads a redirect target.
// Assumes: adv is high for exactly one oscillator period per cycle.
module iss_fetch_ptr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    // Address update at the end of each instruction cycle.
    always_ff @(posedge clk_osc) begin
        if (!rst_n)
            addr_q <= '0;
        else if (adv && load)
            addr_q <= target;
        else if (adv)
            addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
endmodule

// File: rtl/iss_slot.sv
// Issue slot: captures the fetched word at each cycle boundary and
// classifies it as bubble, two-word head, two-word tail or single op.
// Assumes: fetched and is_head are settled when adv is high; words that
// are second halves carry all ones in their GUARD_W upper bits.
module iss_slot
    import iss_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 4
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              flush,
    input  logic [WORD_W-1:0] fetched,
    input  logic              is_head,
    output logic              bubble,
    output logic              active,
    output logic              tail,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b
);
    slot_kind_e        kind_q, kind_nxt;
    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] head_q;
    logic              orphan;

    assign orphan = (fetched[WORD_W-1 -: GUARD_W] == {GUARD_W{1'b1}});

    // Classification of the word entering the slot.
    always_comb begin
        if (flush)
            kind_nxt = SLOT_BUBBLE;
        else if (kind_q == SLOT_HEAD)
            kind_nxt = SLOT_TAIL;
        else if (orphan)
            kind_nxt = SLOT_BUBBLE;
        else if (is_head)
            kind_nxt = SLOT_HEAD;
        else
            kind_nxt = SLOT_SOLO;
    end

    // Slot registers, loaded once per instruction cycle.
    always_ff @(posedge clk_osc) begin
        if (!rst_n) begin
            kind_q <= SLOT_BUBBLE;
            ir_q   <= '0;
            head_q <= '0;
        end else if (adv) begin
            kind_q <= kind_nxt;
            ir_q   <= fetched;
            if (kind_nxt == SLOT_TAIL)
                head_q <= ir_q;
        end
    end

    assign bubble = (kind_q == SLOT_BUBBLE);
    assign tail   = (kind_q == SLOT_TAIL);
    assign active = (kind_q == SLOT_SOLO) || tail;
    assign word_a = tail ? head_q : ir_q;
    assign word_b = tail ? ir_q : '0;
endmodule

// File: rtl/iss_issue_seq.sv
// Issue sequencer top: phase strobes, fetch pointer and issue slot, with
// the flush rule that turns the slot after a redirect into a bubble.
// Assumes: execute-stage flags are meaningful only while exec_en is high.
module iss_issue_seq #(
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 12,
    parameter int PHASES   = 4,
    parameter int DEST_BIT = 9
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] prog_word,
    input  logic              dbl_first,
    input  logic              ex_taken,
    input  logic              ex_skip,
    input  logic              ex_pc_write,
    input  logic [ADDR_W-1:0] ex_target,
    output logic [PHASES-1:0] phase_strobe,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              exec_en,
    output logic [WORD_W-1:0] exec_word,
    output logic [WORD_W-1:0] exec_ext,
    output logic              exec_dest,
    output logic              squash
);
    logic last_ph;
    logic slot_active;
    logic slot_tail;
    logic flush;
    logic redirect;

    iss_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .strobe  (phase_strobe),
        .last    (last_ph)
    );

    // Flags count only in the execute strobe of an issued op.
    assign exec_en  = last_ph && slot_active;
    assign flush    = exec_en && (ex_taken || ex_skip || ex_pc_write);
    assign redirect = exec_en && ex_pc_write;

    iss_fetch_ptr #(.ADDR_W(ADDR_W)) u_fetch (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .adv     (last_ph),
        .load    (redirect),
        .target  (ex_target),
        .addr    (fetch_addr)
    );

    iss_slot #(.WORD_W(WORD_W), .GUARD_W(4)) u_slot (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .adv     (last_ph),
        .flush   (flush),
        .fetched (prog_word),
        .is_head (dbl_first),
        .bubble  (squash),
        .active  (slot_active),
        .tail    (slot_tail),
        .word_a  (exec_word),
        .word_b  (exec_ext)
    );

    assign exec_dest = exec_word[DEST_BIT];
endmodule

// File: rtl/iss_issue_chk.sv
// Property checker for the issue sequencer, bound to every instance.
// Assumes: same parameters as the bound instance.
module iss_issue_chk #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int PHASES = 4
) (
    input logic              clk_osc,
    input logic              rst_n,
    input logic              ex_taken,
    input logic              ex_skip,
    input logic              ex_pc_write,
    input logic [ADDR_W-1:0] ex_target,
    input logic [PHASES-1:0] phase_strobe,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              exec_en,
    input logic              squash
);
    AST_PHASE_ONEHOT: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $countones(phase_strobe) == 1);                                             // R2
    AST_PHASE_WRAP: assert property (@(posedge clk_osc) disable iff (!rst_n)
        phase_strobe[PHASES-1] |=> phase_strobe[0]);                                // R2
    AST_PHASE_STEP: assert property (@(posedge clk_osc) disable iff (!rst_n)
        phase_strobe[0] |=> phase_strobe[1]);                                       // R2
    AST_FETCH_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !phase_strobe[PHASES-1] |=> $stable(fetch_addr));                           // R3
    AST_FETCH_STEP: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (phase_strobe[PHASES-1] && !(exec_en && ex_pc_write))
            |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));                   // R3
    AST_FETCH_LOAD: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (exec_en && ex_pc_write) |=> fetch_addr == $past(ex_target));               // R4
    AST_FLUSH_BUBBLE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (exec_en && (ex_taken || ex_skip || ex_pc_write)) |=> squash);             // R5
    AST_EXEC_PHASE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        exec_en |-> (phase_strobe[PHASES-1] && !squash));                           // R11
    AST_SQUASH_HELD: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !phase_strobe[PHASES-1] |=> $stable(squash));                               // R11
endmodule

bind iss_issue_seq iss_issue_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .PHASES (PHASES)
) u_chk (
    .clk_osc      (clk_osc),
    .rst_n        (rst_n),
    .ex_taken     (ex_taken),
    .ex_skip      (ex_skip),
    .ex_pc_write  (ex_pc_write),
    .ex_target    (ex_target),
    .phase_strobe (phase_strobe),
    .fetch_addr   (fetch_addr),
    .exec_en      (exec_en),
    .squash       (squash)
);

// File: tb/sim_iss_issue_seq.sv
// Bench: program memory, a small execute stage and an architectural
// cycle model; compares every instruction cycle against the model.
module sim_iss_issue_seq;
    localparam int NCYC = 48;

    logic        clk_osc = 1'b0;
    logic        rst_n   = 1'b0;
    logic [15:0] prog_word;
    logic        dbl_first;
    logic        ex_taken, ex_skip, ex_pc_write;
    logic [11:0] ex_target;
    logic [3:0]  phase_strobe;
    logic [11:0] fetch_addr;
    logic        exec_en;
    logic [15:0] exec_word, exec_ext;
    logic        exec_dest, squash;

    logic [15:0] mem [64];
    logic [2:0]  nz_flag = '0;
    logic [11:0] nz_tgt  = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int          exp_kind [NCYC+4];   // 0 bubble, 1 gather, 2 execute
    logic [15:0] exp_word [NCYC+4];
    logic [15:0] exp_ext  [NCYC+4];
    bit          exp_dbl  [NCYC+4];

    always #5 clk_osc = ~clk_osc;

    // Memory read and opcode 0xC marks two-word first words.
    assign prog_word = mem[fetch_addr[5:0]];
    assign dbl_first = (prog_word[15:12] == 4'hC);

    // Execute stage: op 1 skips when bit 0 set, op 2 jumps, op 0xC jumps when bit 8 set.
    wire [3:0] xop      = exec_word[15:12];
    wire       r_skip   = (xop == 4'h1) && exec_word[0];
    wire       r_jmp    = (xop == 4'h2);
    wire       r_goto   = (xop == 4'hC) && exec_word[8];
    assign ex_taken    = exec_en ? r_jmp : nz_flag[0];
    assign ex_skip     = exec_en ? r_skip : nz_flag[1];
    assign ex_pc_write = exec_en ? (r_jmp || r_goto) : nz_flag[2];
    assign ex_target   = exec_en ? {6'd0, (r_goto ? exec_ext[5:0] : exec_word[5:0])} : nz_tgt;

    iss_issue_seq u0 (
        .clk_osc(clk_osc), .rst_n(rst_n), .prog_word(prog_word), .dbl_first(dbl_first),
        .ex_taken(ex_taken), .ex_skip(ex_skip), .ex_pc_write(ex_pc_write),
        .ex_target(ex_target), .phase_strobe(phase_strobe), .fetch_addr(fetch_addr),
        .exec_en(exec_en), .exec_word(exec_word), .exec_ext(exec_ext),
        .exec_dest(exec_dest), .squash(squash)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] plain(input int i);
        logic [5:0] a = 6'(i);
        return {4'h0, 2'b00, a[0], 3'b000, a};
    endfunction

    // Architectural model: cycle cost of each instruction per R1, R4-R8.
    task automatic build_model();
        int         t;
        logic [5:0] pc;
        logic [15:0] w;
        for (int k = 0; k < NCYC + 4; k++) begin
            exp_kind[k] = 0; exp_word[k] = '0; exp_ext[k] = '0; exp_dbl[k] = 0;
        end
        t  = 1;
        pc = '0;
        while (t < NCYC) begin
            w = mem[pc];
            if (w[15:12] == 4'hF) begin
                t++; pc++;
            end else if (w[15:12] == 4'hC) begin
                exp_kind[t] = 1;
                exp_kind[t+1] = 2; exp_word[t+1] = w;
                exp_ext[t+1] = mem[pc + 6'd1]; exp_dbl[t+1] = 1;
                if (w[8]) begin
                    pc = mem[pc + 6'd1][5:0]; t += 3;
                end else begin
                    pc += 6'd2; t += 2;
                end
            end else begin
                exp_kind[t] = 2; exp_word[t] = w;
                if (w[15:12] == 4'h2) begin
                    pc = w[5:0]; t += 2;
                end else if (w[15:12] == 4'h1 && w[0]) begin
                    pc += 6'd2; t += 2;
                end else begin
                    t++; pc++;
                end
            end
        end
    endtask

    task automatic run_prog(input string req);
        int ph;
        int cyc;
        rst_n = 1'b0;
        build_model();
        repeat (3) @(negedge clk_osc);
        chk(phase_strobe == 4'b0001, "R1", "reset phase", 32'(phase_strobe), 32'h1);
        chk(fetch_addr == 12'd0, "R1", "reset fetch", 32'(fetch_addr), 32'h0);
        chk(squash == 1'b1, "R1", "reset squash", 32'(squash), 32'h1);
        chk(exec_en == 1'b0, "R1", "reset exec_en", 32'(exec_en), 32'h0);
        rst_n = 1'b1;
        ph  = 0;
        cyc = 0;
        for (int s = 0; s < NCYC * 4; s++) begin
            @(negedge clk_osc);
            nz_flag = 3'($urandom);
            nz_tgt  = 12'($urandom);
            ph = (ph + 1) % 4;
            chk(phase_strobe == 4'(1 << ph), "R2", "phase strobe",
                32'(phase_strobe), 32'(1 << ph));
            if (ph == 3) begin
                chk(squash == (exp_kind[cyc] == 0), req, $sformatf("squash cyc %0d R10", cyc),
                    32'(squash), 32'(exp_kind[cyc] == 0));
                chk(exec_en == (exp_kind[cyc] == 2), req, $sformatf("exec_en cyc %0d R11", cyc),
                    32'(exec_en), 32'(exp_kind[cyc] == 2));
                if (exp_kind[cyc] == 2) begin
                    chk(exec_word == exp_word[cyc], req, $sformatf("exec_word cyc %0d", cyc),
                        32'(exec_word), 32'(exp_word[cyc]));
                    chk(exec_dest == exp_word[cyc][9], "R9", "exec_dest",
                        32'(exec_dest), 32'(exp_word[cyc][9]));
                    if (exp_dbl[cyc])
                        chk(exec_ext == exp_ext[cyc], "R6", "exec_ext",
                            32'(exec_ext), 32'(exp_ext[cyc]));
                end
                cyc++;
            end
        end
    endtask

    task automatic fill_plain();
        for (int i = 0; i < 64; i++) mem[i] = plain(i);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 64; i++) begin
            int r = int'($urandom % 8);
            logic [11:0] lo = 12'($urandom);
            case (r)
                3:       mem[i] = {4'h1, lo};
                4:       mem[i] = {4'h2, lo};
                5:       if (i < 63) begin
                             mem[i] = {4'hC, lo};
                             mem[i+1] = {4'hF, 12'($urandom)};
                             i++;
                         end else mem[i] = {4'h0, lo};
                6:       mem[i] = {4'hF, lo};
                default: mem[i] = {4'h0, lo};
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R3 R9: straight-line code.
        fill_plain();
        run_prog("R3");
        // R5: untaken skip at 1, taken skip over single word at 3.
        fill_plain();
        mem[1] = 16'h1000; mem[3] = 16'h1001;
        run_prog("R5");
        // R7: taken skip over a two-word op.
        fill_plain();
        mem[3] = 16'h1001; mem[4] = 16'hC000; mem[5] = 16'hF123;
        run_prog("R7");
        // R7: jump that lands directly on a second word.
        fill_plain();
        mem[2] = 16'h2007; mem[6] = 16'hC000; mem[7] = 16'hF0AA;
        run_prog("R7");
        // R4 R6 R8: two-word op without and with redirect, single-word jump.
        fill_plain();
        mem[2] = 16'hC200; mem[3] = 16'hF055;
        mem[5] = 16'hC100; mem[6] = 16'hF00A;
        mem[12] = 16'h2010;
        run_prog("R6/R8/R4");
        // R10: random programs with noise on the flags outside exec_en.
        for (int p = 0; p < 6; p++) begin
            fill_random();
            run_prog("R10");
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule